// File: doc/BRIEF.md
# Strap-configured host bus register slave

This block is the target side of a synchronous host processor port. An external management processor uses it to read and write 16-bit registers inside the chip. The host presents a word address, an address strobe, a chip select and a read/write line. The block answers with an open-drain ready, an open-drain bus-size acknowledge and a tri-stated data bus. On the inside it drives a plain register port: address, write data, a write pulse and a read pulse. Read data comes back one clock after the read pulse. The block also forwards one interrupt request to the host, with a polarity that the chip configuration chooses.

One netlist serves several processor families. Five strap pins are captured once, at the first clock after reset is released. They choose single-rate or double-rate clocking, where every bus state lasts two clocks. They also choose the byte order, the sense of the read/write line, and whether ready arrives together with read data or one clock before it. A fifth strap, nominally the bus width, is accepted but has no effect, because the port is always 16 bits wide. The reset input is asserted asynchronously and must be released in step with the clock.

Top module: `hostbus_slave`

## Requirements
- R1: The straps are loaded from `strap_i` on the first rising clock edge at which `rst_n` is high. Later changes on `strap_i` have no effect until the next reset.
- R2: A transfer starts only when the block is idle, the straps are loaded, and both `ads_n_i` and `cs_n_i` are low at a rising edge. With `cs_n_i` high, the block ignores the strobe, and no output or register pulse follows.
- R3: `strap_i[2]`=0 means `rwc_i` high is a read. `strap_i[2]`=1 means `rwc_i` low is a read. The other level is a write.
- R4: With `strap_i[4]`=1, a read occupies three states after the start edge: access, wait and ready. `reg_re_o` pulses in the access state. `rdy_oe_o` and `data_oe_o` are both high only in the third state.
- R5: With `strap_i[4]`=0, a read has ready alone in the second state and data alone in the third state.
- R6: A write occupies two states: access, then ready. `reg_we_o` pulses in the ready state with `reg_addr_o` equal to the captured address and with write data taken from `data_i` in that clock.
- R7: `bs16_oe_o` is high in every state of every transfer and low when the block is idle.
- R8: `strap_i[1]`=1 swaps the two bytes of the word in both directions. `strap_i[1]`=0 passes the word unchanged.
- R9: With `strap_i[0]`=1, every state lasts two clocks. The register read or write pulse is one clock long and falls in the second clock of its state.
- R10: `strap_i[3]` does not change any timing or data.
- R11: `int_o` equals `irq_req_i` one clock later when `irq_pol_i`=1, and equals its inverse when `irq_pol_i`=0.
- R12: During reset all output enables and register pulses are low. `data_oe_o` is high only in the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| strap_i | input | 5 | Configuration straps: [0] double rate, [1] big endian, [2] read/write sense, [3] width (unused), [4] ready with data |
| ads_n_i | input | 1 | Address strobe, active low |
| cs_n_i | input | 1 | Chip select, active low |
| rwc_i | input | 1 | Read/write control line |
| addr_i | input | 11 | Word address (host address bits 11 to 1) |
| data_i | input | 16 | Host data bus, inbound |
| data_o | output | 16 | Host data bus, outbound |
| data_oe_o | output | 1 | Drive enable for data_o |
| rdy_oe_o | output | 1 | Pull ready pin low when high |
| bs16_oe_o | output | 1 | Pull bus-size pin low when high |
| int_o | output | 1 | Interrupt to host |
| reg_addr_o | output | 11 | Internal register address |
| reg_wdata_o | output | 16 | Internal write data |
| reg_we_o | output | 1 | Internal write pulse |
| reg_re_o | output | 1 | Internal read pulse |
| reg_rdata_i | input | 16 | Internal read data, valid one clock after reg_re_o |
| irq_req_i | input | 1 | Internal interrupt request |
| irq_pol_i | input | 1 | Interrupt polarity: 1 active high |

## Verification
The strap combinations are the hardest part to reach, because each one can only be set through a reset. The stimulus therefore runs four reset epochs that cover double-rate clocking, byte swapping, both read/write senses, early ready and the dead width strap, and it issues writes and read-backs in each epoch. Inside the first epoch the strap pins are driven to their complement to show that the captured values stay in force. A behavioural model in the bench counts clocks from each start edge and predicts every output on every clock.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACC   = 3'd1,
    ST_RWAIT = 3'd2,
    ST_ERDY  = 3'd3,
    ST_RRDY  = 3'd4,
    ST_RDATA = 3'd5,
    ST_WRDY  = 3'd6
  } hbs_state_e;

  // captured strap fields (the width strap is dropped: bus fixed at 16 bits)
  typedef struct packed {
    logic rdy_with_data;  // strap 4
    logic wr_high;        // strap 2
    logic big_end;        // strap 1
    logic clk2x;          // strap 0
  } hbs_cfg_t;

endpackage

// File: rtl/hbs_strap_cap.sv
module hbs_strap_cap
  import hbs_pkg::*;
#(
  parameter int NSTRAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTRAP-1:0] strap_i,
  output hbs_cfg_t          cfg_o,
  output logic              cfg_valid_o
);

  hbs_cfg_t cfg_q, cfg_n;
  logic     valid_q, valid_n;
  logic     load_en;
  logic     width_strap_unused;

  assign width_strap_unused = strap_i[3];
  assign load_en            = ~valid_q;

  always_comb begin
    cfg_n   = cfg_q;
    valid_n = valid_q;
    if (load_en) begin
      cfg_n.rdy_with_data = strap_i[4];
      cfg_n.wr_high       = strap_i[2];
      cfg_n.big_end       = strap_i[1];
      cfg_n.clk2x         = strap_i[0];
      valid_n             = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_n;
      valid_q <= valid_n;
    end
  end

  assign cfg_o       = cfg_q;
  assign cfg_valid_o = valid_q;

endmodule

// File: rtl/hbs_timing.sv
module hbs_timing
  import hbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hbs_cfg_t cfg_i,
  input  logic     cfg_valid_i,
  input  logic     ads_n_i,
  input  logic     cs_n_i,
  input  logic     rwc_i,
  output logic     start_o,
  output logic     cap_o,
  output logic     rdy_oe_o,
  output logic     bs16_oe_o,
  output logic     data_oe_o,
  output logic     re_o,
  output logic     we_o
);

  hbs_state_e st_q, st_n;
  logic       ph_q, ph_n;
  logic       rd_q, rd_n;
  logic       adv;
  logic       rd_sel;

  assign rd_sel  = cfg_i.wr_high ? ~rwc_i : rwc_i;
  assign start_o = (st_q == ST_IDLE) & cfg_valid_i & ~ads_n_i & ~cs_n_i;
  assign adv     = ~cfg_i.clk2x | ph_q;

  always_comb begin
    st_n = st_q;
    ph_n = 1'b0;
    rd_n = rd_q;
    if (st_q == ST_IDLE) begin
      if (start_o) begin
        st_n = ST_ACC;
        rd_n = rd_sel;
      end
    end else if (!adv) begin
      ph_n = 1'b1;
    end else begin
      unique case (st_q)
        ST_ACC:   st_n = rd_q ? (cfg_i.rdy_with_data ? ST_RWAIT : ST_ERDY) : ST_WRDY;
        ST_RWAIT: st_n = ST_RRDY;
        ST_ERDY:  st_n = ST_RDATA;
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      st_q <= st_n;
      ph_q <= ph_n;
      rd_q <= rd_n;
    end
  end

  always_comb begin
    bs16_oe_o = (st_q != ST_IDLE);
    rdy_oe_o  = (st_q == ST_ERDY) | (st_q == ST_RRDY) | (st_q == ST_WRDY);
    data_oe_o = (st_q == ST_RRDY) | (st_q == ST_RDATA);
    re_o      = (st_q == ST_ACC) & rd_q & adv;
    we_o      = (st_q == ST_WRDY) & adv;
    cap_o     = ((st_q == ST_RWAIT) | (st_q == ST_ERDY)) & adv;
  end

endmodule

// File: rtl/hbs_datapath.sv
module hbs_datapath #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cap_i,
  input  logic          big_end_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic          irq_req_i,
  input  logic          irq_pol_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [DW-1:0] data_o,
  output logic          int_o
);

  localparam int NB = DW / 8;

  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] rdat_q, rdat_n;
  logic          int_q, int_n;
  logic [DW-1:0] rd_sw, wr_sw;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rd_sw[b*8 +: 8] = rdat_q[(NB-1-b)*8 +: 8];
    assign wr_sw[b*8 +: 8] = data_i[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    addr_n = start_i ? addr_i : addr_q;
    rdat_n = cap_i ? reg_rdata_i : rdat_q;
    int_n  = irq_pol_i ? irq_req_i : ~irq_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rdat_q <= '0;
      int_q  <= 1'b0;
    end else begin
      addr_q <= addr_n;
      rdat_q <= rdat_n;
      int_q  <= int_n;
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = big_end_i ? wr_sw : data_i;
  assign data_o      = big_end_i ? rd_sw : rdat_q;
  assign int_o       = int_q;

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hbs_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 16,
  parameter int NSTRAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTRAP-1:0] strap_i,
  input  logic              ads_n_i,
  input  logic              cs_n_i,
  input  logic              rwc_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              rdy_oe_o,
  output logic              bs16_oe_o,
  output logic              int_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [DW-1:0]     reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DW-1:0]     reg_rdata_i,
  input  logic              irq_req_i,
  input  logic              irq_pol_i
);

  hbs_cfg_t strap_cfg;
  logic     strap_valid;
  logic     xfer_start;
  logic     rdat_cap;

  hbs_strap_cap #(.NSTRAP(NSTRAP)) u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap_i),
    .cfg_o       (strap_cfg),
    .cfg_valid_o (strap_valid)
  );

  hbs_timing u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (strap_cfg),
    .cfg_valid_i (strap_valid),
    .ads_n_i     (ads_n_i),
    .cs_n_i      (cs_n_i),
    .rwc_i       (rwc_i),
    .start_o     (xfer_start),
    .cap_o       (rdat_cap),
    .rdy_oe_o    (rdy_oe_o),
    .bs16_oe_o   (bs16_oe_o),
    .data_oe_o   (data_oe_o),
    .re_o        (reg_re_o),
    .we_o        (reg_we_o)
  );

  hbs_datapath #(.AW(AW), .DW(DW)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (xfer_start),
    .cap_i       (rdat_cap),
    .big_end_i   (strap_cfg.big_end),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .reg_rdata_i (reg_rdata_i),
    .irq_req_i   (irq_req_i),
    .irq_pol_i   (irq_pol_i),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .data_o      (data_o),
    .int_o       (int_o)
  );

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker
  import hbs_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input hbs_cfg_t cfg,
  input logic     cfg_valid,
  input logic     data_oe_o,
  input logic     rdy_oe_o,
  input logic     bs16_oe_o,
  input logic     reg_we_o,
  input logic     reg_re_o,
  input logic     int_o,
  input logic     irq_req_i,
  input logic     irq_pol_i
);

  logic alive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= 1'b0;
    else        alive_q <= 1'b1;
  end

  // R1: captured straps never move once loaded
  a_r1_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && $past(cfg_valid)) |-> $stable(cfg));

  // R7: ready and data only ever inside a bus-size acknowledged transfer
  a_r7_bs16_covers_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_oe_o || data_oe_o) |-> bs16_oe_o);

  // R6: write pulse is a single clock
  a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R9: read pulse is a single clock
  a_r9_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> !reg_re_o);

  // R12: data is never driven while a write commits
  a_r12_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> !reg_we_o);

  // R4: data drive begins with ready present now or one clock earlier
  a_r4_data_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $rose(data_oe_o)) |-> (rdy_oe_o || $past(rdy_oe_o)));

  // R11: interrupt follows request with the selected polarity
  a_r11_int_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    alive_q |-> (int_o == $past(irq_pol_i ? irq_req_i : !irq_req_i)));

endmodule

bind hostbus_slave hbs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg       (strap_cfg),
  .cfg_valid (strap_valid),
  .data_oe_o (data_oe_o),
  .rdy_oe_o  (rdy_oe_o),
  .bs16_oe_o (bs16_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .int_o     (int_o),
  .irq_req_i (irq_req_i),
  .irq_pol_i (irq_pol_i)
);

// File: tb/sim_hostbus_slave.sv
module sim_hostbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic [4:0]    strap;
  logic          ads_n, cs_n, rwc;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout, reg_wdata, reg_addr_w;
  logic [AW-1:0] reg_addr;
  logic          data_oe, rdy_oe, bs16_oe, int_o, reg_we, reg_re;
  logic [DW-1:0] rdata;
  logic          irq_req, irq_pol;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit chk_en = 0;
  string phase_tag = "R12";

  hostbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .ads_n_i(ads_n), .cs_n_i(cs_n),
    .rwc_i(rwc), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(data_oe),
    .rdy_oe_o(rdy_oe), .bs16_oe_o(bs16_oe), .int_o(int_o), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_re_o(reg_re),
    .reg_rdata_i(rdata), .irq_req_i(irq_req), .irq_pol_i(irq_pol)
  );
  assign reg_addr_w = {5'd0, reg_addr};

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // register file behind the internal port
  logic [DW-1:0] mem [0:(1<<AW)-1];
  initial for (int i = 0; i < (1<<AW); i++) mem[i] = 16'(i * 40503) ^ 16'h5a3c;
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) rdata <= mem[reg_addr];
  end

  function automatic logic [15:0] sw(input logic [15:0] d, input bit big);
    return big ? {d[7:0], d[15:8]} : d;
  endfunction

  // behavioural reference model
  int        m_cnt;
  bit        m_valid, m_rd, m_int;
  bit [4:0]  m_cfg;
  int        m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_valid <= 0; m_rd <= 0; m_int <= 0; m_cfg <= '0; m_addr <= 0;
    end else begin
      m_int <= irq_pol ? irq_req : !irq_req;
      if (!m_valid) begin
        m_valid <= 1; m_cfg <= strap;
      end else if (m_cnt == 0) begin
        if (!ads_n && !cs_n) begin
          m_cnt <= 1; m_rd <= m_cfg[2] ? !rwc : rwc; m_addr <= int'(addr);
        end
      end else if (m_cnt == (m_rd ? 3 : 2) * (m_cfg[0] ? 2 : 1)) m_cnt <= 0;
      else m_cnt <= m_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s act=%h exp=%h", tag, phase_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      int mul, s; bit last, e_bs, e_rdy, e_doe, e_re, e_we;
      mul  = m_cfg[0] ? 2 : 1;
      s    = (m_cnt - 1) / mul;
      last = ((m_cnt - 1) % mul) == mul - 1;
      e_bs = m_cnt != 0;
      e_rdy = e_bs && (m_rd ? (m_cfg[4] ? s == 2 : s == 1) : s == 1);
      e_doe = e_bs && m_rd && s == 2;
      e_re  = e_bs && m_rd && s == 0 && last;
      e_we  = e_bs && !m_rd && s == 1 && last;
      chk(bs16_oe == e_bs, "R7", "bs16_oe", 32'(bs16_oe), 32'(e_bs));
      chk(rdy_oe == e_rdy, m_cfg[4] ? "R4" : "R5", "rdy_oe", 32'(rdy_oe), 32'(e_rdy));
      chk(data_oe == e_doe, "R12", "data_oe", 32'(data_oe), 32'(e_doe));
      chk(reg_re == e_re, m_cfg[0] ? "R9" : "R4", "reg_re", 32'(reg_re), 32'(e_re));
      chk(reg_we == e_we, m_cfg[0] ? "R9" : "R6", "reg_we", 32'(reg_we), 32'(e_we));
      chk(int_o == m_int, "R11", "int_o", 32'(int_o), 32'(m_int));
      if (e_doe)
        chk(dout == sw(mem[m_addr], m_cfg[1]), "R8", "data_o", 32'(dout),
            32'(sw(mem[m_addr], m_cfg[1])));
      if (e_we) begin
        chk(reg_wdata == sw(din, m_cfg[1]), "R6", "reg_wdata", 32'(reg_wdata),
            32'(sw(din, m_cfg[1])));
        chk(int'(reg_addr) == m_addr, "R6", "reg_addr", 32'(reg_addr_w), 32'(m_addr));
      end
    end
  end

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk); #1;
    rst_n = 0; strap = s; ads_n = 1; cs_n = 1;
    repeat (2) @(negedge clk);
    // R12: reset state
    chk({data_oe, rdy_oe, bs16_oe, reg_we, reg_re} == 5'b0, "R12", "reset outputs",
        32'({data_oe, rdy_oe, bs16_oe, reg_we, reg_re}), 32'h0);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus(input logic rwc_lvl, input logic csn, input logic [AW-1:0] a,
                     input logic [15:0] wd);
    @(negedge clk); #1;
    ads_n = 0; cs_n = csn; rwc = rwc_lvl; addr = a; din = wd;
    @(negedge clk); #1;
    ads_n = 1; cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rst_n = 1; strap = 5'b10000; ads_n = 1; cs_n = 1; rwc = 0; addr = '0; din = '0;
    irq_req = 0; irq_pol = 1;
    #2 rst_n = 0;
    chk_en = 1;

    // epoch 1: single rate, little endian, rwc high = read, ready with data
    do_reset(5'b10000);
    phase_tag = "R4";
    bus(1'b0, 1'b0, 11'd5, 16'hA1B2);      // R6 write
    bus(1'b1, 1'b0, 11'd5, 16'h0000);      // R4 read back
    bus(1'b1, 1'b0, 11'd700, 16'h0000);
    phase_tag = "R2";
    bus(1'b1, 1'b1, 11'd9, 16'h0000);      // R2 chip select high: ignored
    bus(1'b0, 1'b1, 11'd5, 16'hFFFF);      // R2 ignored write
    bus(1'b1, 1'b0, 11'd5, 16'h0000);      // R2 word still A1B2
    phase_tag = "R11";
    @(negedge clk); #1 irq_req = 1;
    repeat (3) @(negedge clk); #1 irq_pol = 0;
    repeat (3) @(negedge clk); #1 irq_req = 0;
    repeat (3) @(negedge clk);
    phase_tag = "R1";
    strap = 5'b01111;                       // R1 pins change after capture
    bus(1'b0, 1'b0, 11'd33, 16'h1357);
    bus(1'b1, 1'b0, 11'd33, 16'h0000);

    // epoch 2: single rate, big endian, rwc low = read, early ready
    do_reset(5'b00110);
    phase_tag = "R3";
    bus(1'b1, 1'b0, 11'd12, 16'hC0DE);     // R3 high = write here
    bus(1'b0, 1'b0, 11'd12, 16'h0000);     // R5 early read, R8 swap
    phase_tag = "R8";
    bus(1'b0, 1'b0, 11'd2047, 16'h0000);

    // epoch 3: double rate, ready with data, width strap set
    do_reset(5'b11001);
    phase_tag = "R9";
    bus(1'b0, 1'b0, 11'd100, 16'h2468);
    bus(1'b1, 1'b0, 11'd100, 16'h0000);
    phase_tag = "R10";
    bus(1'b1, 1'b0, 11'd0, 16'h0000);

    // epoch 4: double rate, early ready, big endian, W/R sense, width strap set
    do_reset(5'b01111);
    phase_tag = "R10";
    bus(1'b1, 1'b0, 11'd77, 16'h89AB);
    bus(1'b0, 1'b0, 11'd77, 16'h0000);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule